// File: doc/BRIEF.md
# Transmit Descriptor Status Writeback and Interrupt Decision

This block sits beside the transmit side of a buffer-chaining DMA engine. It works on one 32-bit descriptor control/status word. A frame can span several descriptors: one carries the start flag, one the end flag, and there may be buffers in between. When the DMA engine fetches a descriptor, it hands the word to the block. The block holds that word and keeps a running per-frame request for frame check sequence (FCS) generation. From this it drives an FCS-enable output to the MAC.

When the MAC finishes a buffer, it reports how the buffer went: the retry count, five error causes and a deferral flag. One cycle later the block presents the status word to write back. In that word, ownership is handed back to the host, and the error, deferral and retry flags are filled in. In the same cycle the block decides whether to pulse the transmit-done interrupt. A configuration enable selects the role of bit 28. Either it reports "more than one retry", or it is a host-set per-frame flag that requests an interrupt on success. The error and retry flags are written only by the block; they are never read back.

Top module: `txd_status_wb`

## Requirements
- R1: After reset, `wb_valid_o` and `irq_o` are 0 and the per-frame FCS request is clear.
- R2: A `done_i` cycle produces `wb_valid_o` = 1 for exactly one cycle, on the following cycle. In `wb_desc_o`, bit 31 (ownership, 1 = controller) is 0. Bits 29, 25 (start of frame), 24 (end of frame) and 23:0 are copied from the held descriptor.
- R3: Bit 30 of the writeback is the OR of the underflow, late collision, carrier loss, retry limit and bus parity causes sampled with `done_i`. This holds in any buffer of a frame.
- R4: Bit 26 of the writeback equals `defer_i` sampled with `done_i`.
- R5: Bit 27 is 1 only when the retry count is exactly 1, bit 24 of the held descriptor is 1, and late collision is 0. In every other case it is 0.
- R6: With `cfg_irq_sel_i` = 0, bit 28 is written as 1 exactly when the retry count is 2 or more and bit 24 is set. The host's value of bit 28 is discarded and does not affect the interrupt.
- R7: With `cfg_irq_sel_i` = 1, bit 28 is written back exactly as the host wrote it, whatever the retry count.
- R8: A buffer with any error cause pulses `irq_o` for one cycle together with its writeback. This happens regardless of configuration, bit 24 or bit 28.
- R9: An error-free buffer whose bit 24 is 0 never raises `irq_o`.
- R10: With `cfg_irq_sel_i` = 1, an error-free buffer with bit 24 set raises `irq_o` exactly when its bit 28 is 1. `cfg_ok_irq_off_i` is ignored in this mode.
- R11: With `cfg_irq_sel_i` = 0, an error-free buffer with bit 24 set raises `irq_o` exactly when `cfg_ok_irq_off_i` is 0.
- R12: The per-frame FCS request is bit 29 of the descriptor loaded with bit 25 set, ORed with bit 29 of every later descriptor. `fcs_en_o` is 1 when `cfg_fcs_off_i` is 0, or when the request is set and `cfg_auto_pad_i` is 0.
- R13: With `cfg_auto_pad_i` = 1, bit 29 has no effect: `fcs_en_o` equals the inverse of `cfg_fcs_off_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_valid_i | input | 1 | Descriptor word fetched; load `desc_i` |
| desc_i | input | 32 | Descriptor control/status word from the host |
| cfg_irq_sel_i | input | 1 | 1: bit 28 is the host per-frame interrupt request; 0: bit 28 is the multi-retry flag |
| cfg_ok_irq_off_i | input | 1 | Global suppression of the interrupt on successful frames |
| cfg_fcs_off_i | input | 1 | Global FCS generation disable |
| cfg_auto_pad_i | input | 1 | Auto-pad on transmit active |
| done_i | input | 1 | MAC finished the held buffer; result inputs valid |
| retry_cnt_i | input | RETRY_W | Retries used for the buffer |
| err_uflo_i | input | 1 | Underflow |
| err_lcol_i | input | 1 | Late collision |
| err_lcar_i | input | 1 | Loss of carrier |
| err_rtry_i | input | 1 | Retry limit reached |
| err_bpe_i | input | 1 | Bus parity error |
| defer_i | input | 1 | Channel was busy when transmission was ready |
| fcs_en_o | output | 1 | Append FCS to the current frame |
| wb_valid_o | output | 1 | Writeback word valid (one cycle) |
| wb_desc_o | output | 32 | Status word to write back |
| irq_o | output | 1 | Transmit-done interrupt pulse |

## Verification
The hardest case to reach is a chained frame whose error lands in a middle buffer. It has to raise the interrupt and flag that buffer, while the last-buffer-only retry flags stay clear in every buffer that lacks the end flag. The bench builds three-buffer chains descriptor by descriptor, injecting a retry count on the start buffer and an error on the middle one. It then sweeps each of the five error causes alone through a final buffer whose host flag asks for suppression. The FCS request is walked across a chain, so that a middle buffer sets it and a new start buffer clears it.

// File: rtl/txd_pkg.sv
`timescale 1ns/1ps
package txd_pkg;
  localparam int unsigned DESC_W = 32;
  // field positions decoded by the DMA engine and host
  localparam int unsigned OWN_B = 31;
  localparam int unsigned ERR_B = 30;
  localparam int unsigned FCS_B = 29;
  localparam int unsigned SEL_B = 28;  // multi-retry or per-frame irq request
  localparam int unsigned ONE_B = 27;
  localparam int unsigned DEF_B = 26;
  localparam int unsigned STP_B = 25;
  localparam int unsigned ENP_B = 24;

  typedef struct packed {
    logic uflo;
    logic lcol;
    logic lcar;
    logic rtry;
    logic bpe;
  } tx_err_t;
endpackage

// File: rtl/txd_fcs_ctl.sv
`timescale 1ns/1ps
module txd_fcs_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic stp_i,
  input  logic add_i,
  input  logic cfg_fcs_off_i,
  input  logic cfg_auto_pad_i,
  output logic fcs_en_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_q <= 1'b0;
    else if (load_i) req_q <= stp_i ? add_i : (req_q | add_i);
  end

  assign fcs_en_o = !cfg_fcs_off_i || (req_q && !cfg_auto_pad_i);

  // R13
  pad_masks_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_auto_pad_i && cfg_fcs_off_i) |-> !fcs_en_o);
  // R12
  start_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && stp_i && add_i && !cfg_auto_pad_i) |=> (fcs_en_o || $changed(cfg_auto_pad_i)));
endmodule

// File: rtl/txd_status_build.sv
`timescale 1ns/1ps
module txd_status_build
  import txd_pkg::*;
#(
  parameter int unsigned RETRY_W = 4
) (
  input  logic [DESC_W-1:0]  desc_i,
  input  logic [RETRY_W-1:0] retry_cnt_i,
  input  tx_err_t            err_i,
  input  logic               defer_i,
  input  logic               cfg_irq_sel_i,
  output logic               err_any_o,
  output logic [DESC_W-1:0]  wb_o
);
  localparam logic [RETRY_W-1:0] ONE_RETRY = RETRY_W'(1);

  logic enp, one_f, more_f;

  assign enp       = desc_i[ENP_B];
  assign err_any_o = err_i.uflo | err_i.lcol | err_i.lcar | err_i.rtry | err_i.bpe;
  assign one_f     = enp && (retry_cnt_i == ONE_RETRY) && !err_i.lcol;
  assign more_f    = enp && (retry_cnt_i > ONE_RETRY);

  always_comb begin
    wb_o        = desc_i;
    wb_o[OWN_B] = 1'b0;
    wb_o[ERR_B] = err_any_o;
    wb_o[ONE_B] = one_f;
    wb_o[DEF_B] = defer_i;
    if (!cfg_irq_sel_i) wb_o[SEL_B] = more_f;
  end

  // R5
  one_more_excl_chk: assert final (!(one_f && more_f));
endmodule

// File: rtl/txd_irq_ctl.sv
`timescale 1ns/1ps
module txd_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic err_any_i,
  input  logic enp_i,
  input  logic ltint_i,
  input  logic cfg_irq_sel_i,
  input  logic cfg_ok_irq_off_i,
  output logic irq_o
);
  logic ok_req, irq_d;

  // per-frame request overrides the global success-interrupt disable
  assign ok_req = cfg_irq_sel_i ? ltint_i : !cfg_ok_irq_off_i;
  assign irq_d  = done_i && (err_any_i || (enp_i && ok_req));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_d;
  end

  // R8
  err_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && err_any_i) |=> irq_o);
  // R9
  mid_ok_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !err_any_i && !enp_i) |=> !irq_o);
  // R10
  sel_ltint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !err_any_i && enp_i && cfg_irq_sel_i) |=> (irq_o == $past(ltint_i)));
endmodule

// File: rtl/txd_status_wb.sv
`timescale 1ns/1ps
module txd_status_wb
  import txd_pkg::*;
#(
  parameter int unsigned RETRY_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               desc_valid_i,
  input  logic [31:0]        desc_i,
  input  logic               cfg_irq_sel_i,
  input  logic               cfg_ok_irq_off_i,
  input  logic               cfg_fcs_off_i,
  input  logic               cfg_auto_pad_i,
  input  logic               done_i,
  input  logic [RETRY_W-1:0] retry_cnt_i,
  input  logic               err_uflo_i,
  input  logic               err_lcol_i,
  input  logic               err_lcar_i,
  input  logic               err_rtry_i,
  input  logic               err_bpe_i,
  input  logic               defer_i,
  output logic               fcs_en_o,
  output logic               wb_valid_o,
  output logic [31:0]        wb_desc_o,
  output logic               irq_o
);
  logic [DESC_W-1:0] cur_q, wb_d;
  tx_err_t           err;
  logic              err_any;

  assign err = '{uflo: err_uflo_i, lcol: err_lcol_i, lcar: err_lcar_i,
                 rtry: err_rtry_i, bpe: err_bpe_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cur_q <= '0;
    else if (desc_valid_i) cur_q <= desc_i;
  end

  txd_fcs_ctl u_fcs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .load_i         (desc_valid_i),
    .stp_i          (desc_i[STP_B]),
    .add_i          (desc_i[FCS_B]),
    .cfg_fcs_off_i  (cfg_fcs_off_i),
    .cfg_auto_pad_i (cfg_auto_pad_i),
    .fcs_en_o       (fcs_en_o)
  );

  txd_status_build #(.RETRY_W(RETRY_W)) u_build (
    .desc_i        (cur_q),
    .retry_cnt_i   (retry_cnt_i),
    .err_i         (err),
    .defer_i       (defer_i),
    .cfg_irq_sel_i (cfg_irq_sel_i),
    .err_any_o     (err_any),
    .wb_o          (wb_d)
  );

  txd_irq_ctl u_irq (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .done_i           (done_i),
    .err_any_i        (err_any),
    .enp_i            (cur_q[ENP_B]),
    .ltint_i          (cur_q[SEL_B]),
    .cfg_irq_sel_i    (cfg_irq_sel_i),
    .cfg_ok_irq_off_i (cfg_ok_irq_off_i),
    .irq_o            (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_o <= 1'b0;
      wb_desc_o  <= '0;
    end else begin
      wb_valid_o <= done_i;
      if (done_i) wb_desc_o <= wb_d;
    end
  end

  // R2
  wb_follows_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (wb_valid_o && !wb_desc_o[OWN_B]));
  // R2
  wb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> !wb_valid_o);
  // R8
  irq_with_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wb_valid_o);
  // R3
  err_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && (err_uflo_i || err_bpe_i)) |=> wb_desc_o[ERR_B]);
  // R5
  one_needs_enp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !cur_q[ENP_B]) |=> !wb_desc_o[ONE_B]);
endmodule

// File: tb/txd_status_wb_bench.sv
`timescale 1ns/1ps
module txd_status_wb_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic desc_valid = 1'b0;
  logic [31:0] desc = '0;
  logic sel = 1'b0, okoff = 1'b0, fcsoff = 1'b1, apad = 1'b0;
  logic done = 1'b0;
  logic [3:0] retry = '0;
  logic uflo = 0, lcol = 0, lcar = 0, rtry = 0, bpe = 0, dfr = 0;
  logic fcs_en, wb_valid, irq;
  logic [31:0] wb_desc;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  txd_status_wb u_txd_status_wb (
    .clk_i(clk), .rst_ni(rst_n), .desc_valid_i(desc_valid), .desc_i(desc),
    .cfg_irq_sel_i(sel), .cfg_ok_irq_off_i(okoff), .cfg_fcs_off_i(fcsoff),
    .cfg_auto_pad_i(apad), .done_i(done), .retry_cnt_i(retry),
    .err_uflo_i(uflo), .err_lcol_i(lcol), .err_lcar_i(lcar), .err_rtry_i(rtry),
    .err_bpe_i(bpe), .defer_i(dfr), .fcs_en_o(fcs_en), .wb_valid_o(wb_valid),
    .wb_desc_o(wb_desc), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one buffer: load descriptor, report MAC result, check writeback and pulse
  task automatic buf_run(input string req, input logic [31:0] d, input logic [3:0] rc,
                         input logic [4:0] causes, input logic df,
                         input logic [31:0] exp_wb, input logic exp_irq);
    @(negedge clk); desc_valid = 1; desc = d;
    @(negedge clk); desc_valid = 0; done = 1; retry = rc;
    {uflo, lcol, lcar, rtry, bpe} = causes; dfr = df;
    @(negedge clk); done = 0; {uflo, lcol, lcar, rtry, bpe} = '0; dfr = 0; retry = '0;
    chk({req, " wb_valid"}, {31'd0, wb_valid}, 32'd1);
    chk({req, " word"}, wb_desc, exp_wb);
    chk({req, " irq"}, {31'd0, irq}, {31'd0, exp_irq});
    @(negedge clk);
    chk("R2 strobe one cycle", {31'd0, wb_valid}, 32'd0);
    chk("R8 irq one cycle", {31'd0, irq}, 32'd0);
  endtask

  task automatic fcs_load(input string req, input logic [31:0] d, input logic exp);
    @(negedge clk); desc_valid = 1; desc = d;
    @(negedge clk); desc_valid = 0;
    chk(req, {31'd0, fcs_en}, {31'd0, exp});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 wb_valid", {31'd0, wb_valid}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 fcs request clear", {31'd0, fcs_en}, 32'd0);
  endtask

  task automatic t_retry_flags_sel0;
    sel = 0; okoff = 0;
    buf_run("R2 R11 plain", 32'h8300_1234, 4'd0, 5'b0, 0, 32'h0300_1234, 1);
    buf_run("R4 R5 R6 one retry, host bit28 dropped", 32'h9300_1234, 4'd1, 5'b0, 1, 32'h0F00_1234, 1);
    okoff = 1;
    buf_run("R6 R11 more retries, ok irq off", 32'h8300_0055, 4'd5, 5'b0, 0, 32'h1300_0055, 0);
    buf_run("R6 host bit28 not an irq request", 32'h9300_0056, 4'd0, 5'b0, 0, 32'h0300_0056, 0);
  endtask

  task automatic t_sel1;
    sel = 1; okoff = 1;
    buf_run("R7 R10 ltint set", 32'h9300_0077, 4'd3, 5'b0, 0, 32'h1300_0077, 1);
    okoff = 0;
    buf_run("R5 R10 ltint clear", 32'h8300_0078, 4'd1, 5'b0, 0, 32'h0B00_0078, 0);
    buf_run("R7 ltint kept at zero retries", 32'hB100_0079, 4'd0, 5'b0, 0, 32'h3100_0079, 1);
  endtask

  task automatic t_chain_error;
    sel = 0; okoff = 0;
    buf_run("R5 R6 R9 start buffer", 32'h8200_0001, 4'd2, 5'b0, 0, 32'h0200_0001, 0);
    buf_run("R3 R8 middle underflow", 32'h8000_0002, 4'd0, 5'b10000, 0, 32'h4000_0002, 1);
    buf_run("R3 R5 end late collision", 32'h8100_0003, 4'd1, 5'b01000, 0, 32'h4100_0003, 1);
  endtask

  task automatic t_each_cause;
    sel = 1; okoff = 1;
    for (int i = 0; i < 5; i++)
      buf_run($sformatf("R3 R8 cause %0d", i), 32'h8100_0010, 4'd0,
              5'b00001 << i, 0, 32'h4100_0010, 1);
  endtask

  task automatic t_fcs;
    fcsoff = 1; apad = 0;
    fcs_load("R12 start without request", 32'h8200_0000, 0);
    fcs_load("R12 middle requests", 32'hA000_0000, 1);
    fcs_load("R12 request held to end", 32'h8100_0000, 1);
    fcs_load("R12 new start clears", 32'h8200_0000, 0);
    fcs_load("R12 start with request", 32'hA300_0000, 1);
    apad = 1;
    @(negedge clk);
    chk("R13 auto pad masks request", {31'd0, fcs_en}, 32'd0);
    fcsoff = 0;
    @(negedge clk);
    chk("R13 global enable under auto pad", {31'd0, fcs_en}, 32'd1);
    apad = 0;
    fcs_load("R12 global enable without request", 32'h8200_0000, 1);
    fcsoff = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_retry_flags_sel0();
    t_sel1();
    t_chain_error();
    t_each_cause();
    t_fcs();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule